// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Supervisor

This block watches a recovered line clock and decides whether it is running at the rate the reference clock implies. It runs entirely on the reference clock. The recovered side reaches it only as a toggle line that flips once per recovered event, where an event is one period of the recovered clock divided by `EVT_DIV`. The toggle is brought across on a synchronizer chain. An edge detector turns each flip into a one-cycle pulse.

Time is cut into gate windows of `WINDOW` reference cycles. At the close of each window the number of events is compared with the count that the selected line rate and reference frequency predict. If the two differ by more than a parts-per-million tolerance, the window is marked bad. A run of consecutive bad windows raises the lock-lost flag. A longer run of consecutive good windows lowers it again. Every time value is a parameter, so a bench can shrink the windows, the tolerance and the run lengths.

Top module: `freq_lock_monitor`

## Requirements
- R1: `lock_lost` is 1 while `rst_n` is low and stays 1 after reset until the clear rule of R6 is met.
- R2: Each transition of `rec_tgl`, in either direction, is one recovered event. The first reference edge after reset release opens the first window, and each window spans `WINDOW` reference edges. An event whose synchronized pulse is counted on the closing edge of a window belongs to that window.
- R3: The expected count is `WINDOW * M / EVT_DIV`, where M is the line-to-reference ratio. M is chosen by `{rate_sel, ref_sel}`: 000 gives 8 (19.44 MHz ref, 155.52 Mbit/s); 001 gives 2 (77.76 MHz); 010 and 011 give 1 (155.52 MHz); 100 gives 8 (17.408 MHz ref, 139.264 Mbit/s); 101, 110 and 111 give 1 (139.264 MHz).
- R4: A window is bad when |count − expected| is greater than floor(expected × `TOL_PPM` / 1,000,000). A difference equal to that bound is good.
- R5: While `lock_lost` is 0, `DECLARE_WINS` consecutive bad windows set it to 1.
- R6: While `lock_lost` is 1, `CLEAR_WINS` consecutive good windows set it to 0.
- R7: A window of the opposite kind restarts the run being counted, so bad and good windows that alternate never change the flag.
- R8: `lock_lost` changes only on the reference edge that follows a window's closing edge, and it holds its value through the rest of the window.
- R9: The selection controls are taken from the values present when a window is evaluated, so a change made at the start of a window applies to that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all state runs on its rising edge |
| rst_n | input | 1 | Active-low reset |
| rec_tgl | input | 1 | Asynchronous toggle, one flip per recovered event |
| rate_sel | input | 1 | Line rate: 0 = 155.52 Mbit/s, 1 = 139.264 Mbit/s |
| ref_sel | input | 2 | Reference frequency code, decoded together with rate_sel (R3) |
| lock_lost | output | 1 | 1 while the recovered frequency is judged out of tolerance |

## Verification
The closing of a gate window and the arrival of a synchronized event pulse can fall on the same reference edge. If the design handles this edge badly, an event is lost or counted twice. The bench provokes this with windows whose event count is set exactly, with the last flip placed so that its pulse lands on the closing edge. Those windows use the ratio-1 setting, where the tolerance is a single event. A window of expected-minus-one events, with its last event on the closing edge, must be judged good. Expected-minus-two must be judged bad. A miscount in either direction therefore shows up in the flag after the persistence run.

// File: rtl/flm_pkg.sv
package flm_pkg;

   // line-rate to reference-frequency ratio selected by {rate, ref code}
   function automatic int unsigned line_ratio(input logic rate, input logic [1:0] code);
      case ({rate, code})
         3'b000:  return 8;   // 19.44 MHz for the 155.52 Mbit/s rate
         3'b001:  return 2;   // 77.76 MHz
         3'b010,
         3'b011:  return 1;   // 155.52 MHz
         3'b100:  return 8;   // 17.408 MHz for the 139.264 Mbit/s rate
         default: return 1;   // 139.264 MHz
      endcase
   endfunction

   function automatic longint unsigned nominal_events(input longint unsigned win,
                                                      input longint unsigned ratio,
                                                      input longint unsigned div);
      return (win * ratio) / div;
   endfunction

   function automatic longint unsigned slack_events(input longint unsigned nominal,
                                                    input longint unsigned ppm);
      return (nominal * ppm) / 64'd1000000;
   endfunction

endpackage

// File: rtl/flm_toggle_sync.sv
module flm_toggle_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_async,
   output logic evt_pulse
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("flm_toggle_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], tgl_async};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign evt_pulse = chain_q[STAGES-1] ^ last_q;

   // R2
   evt_follows_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> (last_q != $past(last_q)));
endmodule

// File: rtl/flm_gate_counter.sv
module flm_gate_counter #(
   parameter int WINDOW = 65536,
   parameter int CW     = $clog2(WINDOW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_pulse,
   output logic          win_valid,
   output logic [CW-1:0] win_count
);
   localparam int TW = $clog2(WINDOW);

   logic [TW-1:0] tick_q;
   logic [CW-1:0] acc_q;
   logic          closing;

   assign closing = (tick_q == TW'(WINDOW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q    <= '0;
         acc_q     <= '0;
         win_valid <= 1'b0;
         win_count <= '0;
      end else begin
         win_valid <= closing;
         if (closing) begin
            tick_q    <= '0;
            acc_q     <= '0;
            win_count <= acc_q + CW'(evt_pulse);
         end else begin
            tick_q <= tick_q + 1'b1;
            acc_q  <= acc_q + CW'(evt_pulse);
         end
      end
   end

   // R2
   gate_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_count <= CW'(WINDOW)));

   // R2
   gate_single_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |=> !win_valid);
endmodule

// File: rtl/flm_window_judge.sv
module flm_window_judge #(
   parameter int WINDOW  = 65536,
   parameter int EVT_DIV = 16,
   parameter int TOL_PPM = 100,
   parameter int CW      = $clog2(WINDOW + 1)
) (
   input  logic          rate_sel,
   input  logic [1:0]    ref_sel,
   input  logic [CW-1:0] win_count,
   output logic          win_good
);
   logic [CW-1:0] nominal_tab [8];
   logic [CW-1:0] slack_tab   [8];

   generate
      for (genvar g = 0; g < 8; g++) begin : g_sel
         localparam longint unsigned NOM = flm_pkg::nominal_events(
            longint'(WINDOW), longint'(flm_pkg::line_ratio(g[2], g[1:0])), longint'(EVT_DIV));
         localparam longint unsigned SLK = flm_pkg::slack_events(NOM, longint'(TOL_PPM));
         assign nominal_tab[g] = CW'(NOM);
         assign slack_tab[g]   = CW'(SLK);
      end
   endgenerate

   logic [2:0]    idx;
   logic [CW-1:0] nominal;
   logic [CW-1:0] slack;
   logic [CW-1:0] deviation;

   always_comb begin
      idx       = {rate_sel, ref_sel};
      nominal   = nominal_tab[idx];
      slack     = slack_tab[idx];
      deviation = (win_count >= nominal) ? (win_count - nominal) : (nominal - win_count);
      win_good  = (deviation <= slack);
   end
endmodule

// File: rtl/flm_persist.sv
module flm_persist #(
   parameter int DECLARE_WINS = 6,
   parameter int CLEAR_WINS   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win_valid,
   input  logic win_good,
   output logic lock_lost
);
   localparam int RUN_MAX = (DECLARE_WINS > CLEAR_WINS) ? DECLARE_WINS : CLEAR_WINS;
   localparam int RW      = $clog2(RUN_MAX + 1);

   logic [RW-1:0] bad_run_q;
   logic [RW-1:0] good_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_lost  <= 1'b1;
         bad_run_q  <= '0;
         good_run_q <= '0;
      end else if (win_valid) begin
         if (win_good) begin
            bad_run_q <= '0;
            if (lock_lost) begin
               if (good_run_q == RW'(CLEAR_WINS - 1)) begin
                  lock_lost  <= 1'b0;
                  good_run_q <= '0;
               end else begin
                  good_run_q <= good_run_q + 1'b1;
               end
            end
         end else begin
            good_run_q <= '0;
            if (!lock_lost) begin
               if (bad_run_q == RW'(DECLARE_WINS - 1)) begin
                  lock_lost <= 1'b1;
                  bad_run_q <= '0;
               end else begin
                  bad_run_q <= bad_run_q + 1'b1;
               end
            end
         end
      end
   end

   // R5
   declare_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_lost) |-> $past(win_valid && !win_good));

   // R6
   clear_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_lost) |-> $past(win_valid && win_good));

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |=> $stable(lock_lost));

   // R7
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_run_q < RW'(DECLARE_WINS)) && (good_run_q < RW'(CLEAR_WINS)));
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
   parameter int WINDOW       = 65536,
   parameter int EVT_DIV      = 16,
   parameter int TOL_PPM      = 100,
   parameter int DECLARE_WINS = 6,
   parameter int CLEAR_WINS   = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       rec_tgl,
   input  logic       rate_sel,
   input  logic [1:0] ref_sel,
   output logic       lock_lost
);
   localparam int CW = $clog2(WINDOW + 1);

   generate
      if (WINDOW < 16) begin : g_chk_win
         $error("freq_lock_monitor: WINDOW too short");
      end
      if (EVT_DIV < 16) begin : g_chk_div
         $error("freq_lock_monitor: EVT_DIV must keep the toggle below a quarter of the reference rate");
      end
      if ((WINDOW % EVT_DIV) != 0) begin : g_chk_mod
         $error("freq_lock_monitor: WINDOW must be a multiple of EVT_DIV");
      end
      if (DECLARE_WINS < 1 || CLEAR_WINS < 1) begin : g_chk_run
         $error("freq_lock_monitor: persistence runs must be at least one window");
      end
      if (TOL_PPM < 0 || TOL_PPM >= 1000000) begin : g_chk_tol
         $error("freq_lock_monitor: TOL_PPM out of range");
      end
   endgenerate

   logic          evt_pulse;
   logic          win_valid;
   logic [CW-1:0] win_count;
   logic          win_good;

   flm_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .tgl_async (rec_tgl),
      .evt_pulse (evt_pulse)
   );

   flm_gate_counter #(.WINDOW(WINDOW), .CW(CW)) u_gate (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .win_valid (win_valid),
      .win_count (win_count)
   );

   flm_window_judge #(.WINDOW(WINDOW), .EVT_DIV(EVT_DIV), .TOL_PPM(TOL_PPM), .CW(CW)) u_judge (
      .rate_sel  (rate_sel),
      .ref_sel   (ref_sel),
      .win_count (win_count),
      .win_good  (win_good)
   );

   flm_persist #(.DECLARE_WINS(DECLARE_WINS), .CLEAR_WINS(CLEAR_WINS)) u_persist (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .win_valid (win_valid),
      .win_good  (win_good),
      .lock_lost (lock_lost)
   );

   // R1
   reset_flag_chk: assert property (@(posedge clk_ref) !rst_n |=> lock_lost);
endmodule

// File: tb/freq_lock_monitor_test.sv
module freq_lock_monitor_test;
   localparam int W    = 512;
   localparam int DIV  = 32;
   localparam int TOL  = 100000;
   localparam int DECL = 3;
   localparam int CLR  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rec_tgl = 1'b0;
   logic       rate_sel = 1'b0;
   logic [1:0] ref_sel = 2'd0;
   logic       lock_lost;

   int checks = 0;
   int errors = 0;

   bit    exp_q[$];
   string tag_q[$];

   bit m_lol  = 1'b1;
   int m_bad  = 0;
   int m_good = 0;
   int spill  = 0;
   bit fl[W];

   always #4 clk = ~clk;

   freq_lock_monitor #(
      .WINDOW(W), .EVT_DIV(DIV), .TOL_PPM(TOL),
      .DECLARE_WINS(DECL), .CLEAR_WINS(CLR), .SYNC_STAGES(2)
   ) uut (
      .clk_ref(clk), .rst_n(rst_n), .rec_tgl(rec_tgl),
      .rate_sel(rate_sel), .ref_sel(ref_sel), .lock_lost(lock_lost)
   );

   function automatic int ratio_of(bit r, bit [1:0] s);
      if (!r) return (s == 2'd0) ? 8 : (s == 2'd1) ? 2 : 1;
      return (s == 2'd0) ? 8 : 1;
   endfunction

   task automatic check(bit act, bit expv, string tag);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: lock_lost=%0b expected %0b at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic fill_period(int per);
      for (int i = 0; i < W; i++) fl[i] = ((i % per) == 0);
   endtask

   // n flips two cycles apart; with on_close the last one lands on the closing edge
   task automatic fill_exact(int n, bit on_close);
      for (int i = 0; i < W; i++) fl[i] = 1'b0;
      for (int j = 0; j < n - 1; j++) fl[20 + 2 * j] = 1'b1;
      if (on_close) fl[W - 4] = 1'b1;
      else          fl[20 + 2 * (n - 1)] = 1'b1;
   endtask

   task automatic run_window(bit r, bit [1:0] s, string tag);
      int cnt, nom, slack, dev;
      bit good;
      cnt = spill;
      spill = 0;
      for (int i = 0; i < W; i++) begin
         @(negedge clk);
         if (i == 0) begin
            rate_sel = r;
            ref_sel  = s;
         end
         if (fl[i]) begin
            rec_tgl = ~rec_tgl;
            if (i <= W - 4) cnt++;
            else            spill++;
         end
      end
      nom   = W * ratio_of(r, s) / DIV;
      slack = nom * TOL / 1000000;
      dev   = (cnt > nom) ? cnt - nom : nom - cnt;
      good  = (dev <= slack);
      if (good) begin
         m_bad = 0;
         if (m_lol) begin
            m_good++;
            if (m_good == CLR) begin m_lol = 1'b0; m_good = 0; end
         end
      end else begin
         m_good = 0;
         if (!m_lol) begin
            m_bad++;
            if (m_bad == DECL) begin m_lol = 1'b1; m_bad = 0; end
         end
      end
      exp_q.push_back(m_lol);
      tag_q.push_back(tag);
   endtask

   task automatic per_wins(int per, int n, bit r, bit [1:0] s, string tag);
      fill_period(per);
      for (int k = 0; k < n; k++) run_window(r, s, tag);
   endtask

   task automatic exact_win(int n, bit on_close, string tag);
      fill_exact(n, on_close);
      run_window(1'b0, 2'd2, tag);
   endtask

   // monitor: after each evaluation edge compare, and re-check mid-window
   task automatic monitor();
      bit cur;
      cur = 1'b1;
      @(posedge clk);
      forever begin
         repeat (W / 2) @(posedge clk);
         @(negedge clk);
         check(lock_lost, cur, "R8 mid-window hold");
         repeat (W / 2) @(posedge clk);
         @(negedge clk);
         if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            check(lock_lost, cur, tag_q.pop_front());
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(lock_lost, 1'b1, "R1 during reset");
      rst_n = 1'b1;
      check(lock_lost, 1'b1, "R1 after release");
      fork
         monitor();
      join_none
      // 19.44 MHz ref: nominal 128, slack 12
      per_wins(4, CLR, 1'b0, 2'd0, "R6 clear after good run");
      per_wins(5, 2, 1'b0, 2'd0, "R5 bad run below threshold");
      per_wins(4, 1, 1'b0, 2'd0, "R7 good window restarts bad run");
      per_wins(5, DECL, 1'b0, 2'd0, "R5 declare after bad run");
      per_wins(4, 3, 1'b0, 2'd0, "R6 good run below threshold");
      per_wins(5, 1, 1'b0, 2'd0, "R7 bad window restarts good run");
      per_wins(4, CLR, 1'b0, 2'd0, "R6 clear again");
      // 155.52 MHz ref: nominal 16, slack 1
      per_wins(32, 2, 1'b0, 2'd2, "R9 selection change to ratio 1");
      per_wins(40, DECL, 1'b0, 2'd2, "R3 ratio 1 declare");
      per_wins(32, CLR, 1'b0, 2'd2, "R3 ratio 1 clear");
      exact_win(17, 1'b0, "R4 deviation equal to slack is good");
      exact_win(15, 1'b1, "R2 event on closing edge counted");
      exact_win(14, 1'b0, "R4 deviation above slack is bad");
      exact_win(18, 1'b0, "R4 excess count is bad");
      exact_win(14, 1'b1, "R2 R4 declare with closing-edge event");
      exact_win(15, 1'b1, "R2 closing-edge good window");
      exact_win(15, 1'b1, "R2 closing-edge good window");
      exact_win(15, 1'b1, "R2 closing-edge good window");
      exact_win(15, 1'b1, "R2 R6 clear with closing-edge events");
      // 139.264 Mbit/s rate
      per_wins(4, 2, 1'b1, 2'd0, "R3 17.408 MHz ref ratio 8");
      per_wins(4, DECL, 1'b1, 2'd1, "R9 R3 139.264 MHz ref ratio 1 declare");
      per_wins(32, CLR, 1'b1, 2'd1, "R3 139.264 MHz ref clear");
      // 77.76 MHz ref: nominal 32, slack 3
      per_wins(16, 2, 1'b0, 2'd1, "R3 77.76 MHz ref ratio 2");
      per_wins(4, DECL, 1'b0, 2'd1, "R3 ratio 2 declare");
      per_wins(16, CLR, 1'b0, 2'd1, "R3 ratio 2 clear");
      repeat (W + 8) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule